// File: doc/BRIEF.md
# Arithmetic Unit with Condition Flags

This block is the execute-stage arithmetic and logic unit of a small load-store core. It works on 32-bit two's-complement data. It takes an operation code, a first register operand and a second operand. The second operand is either a register value or a 13-bit signed constant that the block widens to 32 bits. The 32-bit result is combinational and is ready in the same cycle as the inputs.

Beside the result path there is a 32-bit status word that holds four condition flags: negative, zero, overflow and carry/borrow. The flags are recomputed from every operation, but they are written into the status register at the rising clock edge only when the flag-setting qualifier is high. Plain operations pass through the datapath and leave the stored flags as they were. A synchronous reset clears the whole status word.

The design has no sequencer. Its only stored state is the flag register, which has two behaviours in a cycle: load (flag-setting operation) and hold (plain operation or idle). Reset overrides both.

Top module: `alu_cc_unit`

## Requirements
- R1: With `op_sel` = 0 (add), `result` equals first operand plus second operand, modulo 2^32, in the same cycle.
- R2: With `op_sel` = 1 (subtract), `result` equals first operand minus second operand, modulo 2^32.
- R3: `op_sel` = 2 gives bitwise AND and `op_sel` = 3 gives bitwise OR of the two operands. `op_sel` = 4 gives the bitwise complement of the first operand, and the second operand has no effect.
- R4: When `use_imm` is 1, the second operand is `imm13` sign-extended to 32 bits, and `rs2_val` has no effect. When `use_imm` is 0, `rs2_val` is the second operand.
- R5: After a flag-setting operation, the negative flag equals bit 31 of that operation's result. The zero flag is 1 exactly when that result was all zeros.
- R6: After a flag-setting add, the carry flag is the carry out of bit 31. After a flag-setting subtract, it is 1 exactly when there was a borrow, that is, when the first operand is below the second as unsigned values.
- R7: After a flag-setting add or subtract, the overflow flag is 1 exactly when the true signed result lies outside the signed 32-bit range.
- R8: After a flag-setting logical operation (codes 2, 3 and 4), carry and overflow are 0.
- R9: When `set_cc` is 0 at a clock edge, `psr` does not change at that edge.
- R10: `psr` carries the negative flag at bit 23, zero at bit 22, overflow at bit 21 and carry at bit 20. All other bits read 0. A synchronous `rst` clears `psr` to zero at the next edge.
- R11: Codes 5 to 7 give a `result` of zero. With `set_cc` = 1 they load the flags as a logical operation does, so Z=1 and N, V and C are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 not |
| set_cc | input | 1 | High for the flag-setting variant of the operation |
| use_imm | input | 1 | Selects the sign-extended immediate as the second operand |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| imm13 | input | 13 | Signed immediate constant |
| result | output | 32 | Combinational operation result |
| psr | output | 32 | Status word that holds the stored flags |

## Verification
The clocked properties assume that `op_sel`, `set_cc`, `use_imm` and the operands are stable through each rising edge, so that the flags stored at that edge belong to the result seen just before it. The bench changes every input on the falling edge only, so this assumption always holds. The random stimulus takes all eight operation codes and both operand sources, and it places extreme values (0, all ones, the sign boundary) among the random operands so that the carry and overflow corners are reached.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 13;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_NOT  = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } flags_t;

    localparam int PSR_N_BIT = 23;
    localparam int PSR_Z_BIT = 22;
    localparam int PSR_V_BIT = 21;
    localparam int PSR_C_BIT = 20;
endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        operand = use_imm ? imm_ext : reg_val;
    end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output flags_t            flags_nxt
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] add_wide;
    logic [DATA_W:0] sub_wide;
    logic            arith_c;
    logic            arith_v;

    always_comb begin
        add_wide = {1'b0, opa} + {1'b0, opb};
        sub_wide = {1'b0, opa} - {1'b0, opb};
        res      = '0;
        arith_c  = 1'b0;
        arith_v  = 1'b0;
        unique case (op_sel)
            OP_ADD: begin
                res     = add_wide[DATA_W-1:0];
                arith_c = add_wide[DATA_W];
                arith_v = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            OP_SUB: begin
                res     = sub_wide[DATA_W-1:0];
                arith_c = sub_wide[DATA_W];
                arith_v = (opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]);
            end
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_NOT:  res = ~opa;
            default: res = '0;
        endcase
        flags_nxt.neg  = res[MSB];
        flags_nxt.zero = (res == '0);
        flags_nxt.ovf  = arith_v;
        flags_nxt.cry  = arith_c;
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] psr
);
    typedef enum logic {ST_HOLD, ST_LOAD} ccr_act_e;

    ccr_act_e act;
    flags_t   flags_q;

    always_comb begin
        act = load ? ST_LOAD : ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            unique case (act)
                ST_LOAD: flags_q <= flags_in;
                ST_HOLD: flags_q <= flags_q;
                default: flags_q <= flags_q;
            endcase
        end
    end

    always_comb begin
        psr            = '0;
        psr[PSR_N_BIT] = flags_q.neg;
        psr[PSR_Z_BIT] = flags_q.zero;
        psr[PSR_V_BIT] = flags_q.ovf;
        psr[PSR_C_BIT] = flags_q.cry;
    end

    AST_HOLD_PLAIN: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(psr)); // R9
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst) load |=> (psr[PSR_C_BIT] == $past(flags_in.cry))); // R6
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_sel,
    input  logic              set_cc,
    input  logic              use_imm,
    input  logic [31:0]       rs1_val,
    input  logic [31:0]       rs2_val,
    input  logic [12:0]       imm13,
    output logic [31:0]       result,
    output logic [31:0]       psr
);
    logic [DATA_W-1:0] opb;
    flags_t            flags_nxt;

    alu_operand_mux #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opmux (
        .use_imm (use_imm),
        .reg_val (rs2_val),
        .imm_val (imm13),
        .operand (opb)
    );

    alu_datapath #(.DATA_W(DATA_W)) u_dp (
        .op_sel    (op_sel),
        .opa       (rs1_val),
        .opb       (opb),
        .res       (result),
        .flags_nxt (flags_nxt)
    );

    alu_flag_reg #(.DATA_W(DATA_W)) u_ccr (
        .clk      (clk),
        .rst      (rst),
        .load     (set_cc),
        .flags_in (flags_nxt),
        .psr      (psr)
    );

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) set_cc |=> (psr[PSR_Z_BIT] == ($past(result) == '0))); // R5
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst) set_cc |=> (psr[PSR_N_BIT] == $past(result[31]))); // R5
    AST_LOGIC_CV: assert property (@(posedge clk) disable iff (rst) (set_cc && op_sel >= 3'd2) |=> (psr[PSR_C_BIT] == 1'b0 && psr[PSR_V_BIT] == 1'b0)); // R8
    AST_IMM_SEXT: assert property (@(posedge clk) disable iff (rst) (use_imm && op_sel == 3'd3 && rs1_val == '0) |-> (result[31:12] == {20{imm13[12]}})); // R4
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst) set_cc && op_sel >= 3'd5 |-> result == '0); // R11
endmodule

// File: tb/alu_cc_unit_tb.sv
`timescale 1ns/1ps
module alu_cc_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = '0;
    logic        set_cc = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [12:0] imm13 = '0;
    logic [31:0] result;
    logic [31:0] psr;

    int checks = 0;
    int failures = 0;
    logic [3:0] mflags = 4'b0000; // {N,Z,V,C}

    always #5 clk = ~clk;

    alu_cc_unit u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .set_cc(set_cc), .use_imm(use_imm),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .imm13(imm13), .result(result), .psr(psr)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] psr_of(input logic [3:0] f);
        logic [31:0] p;
        p = 32'h0;
        p[23] = f[3]; p[22] = f[2]; p[21] = f[1]; p[20] = f[0];
        return p;
    endfunction

    // returns {N,Z,V,C,result}
    function automatic logic [35:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic c, v;
        longint sa, sb, sr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        c = 1'b0; v = 1'b0;
        case (op)
            3'd0: begin
                r = a + b;
                c = ({32'h0, a} + {32'h0, b}) > 64'hFFFF_FFFF;
                sr = sa + sb;
                v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            3'd1: begin
                r = a - b;
                c = (a < b);
                sr = sa - sb;
                v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = ~a;
            default: r = 32'h0;
        endcase
        return {r[31], (r == 32'h0), v, c, r};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3, 3'd4: return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic cc, input logic imm_sel,
                          input logic [31:0] a, input logic [31:0] b, input logic [12:0] im);
        logic [31:0] opb;
        logic [35:0] m;
        @(negedge clk);
        op_sel = op; set_cc = cc; use_imm = imm_sel;
        rs1_val = a; rs2_val = b; imm13 = im;
        opb = imm_sel ? {{19{im[12]}}, im} : b;
        m = model(op, a, opb);
        #1;
        check(imm_sel ? "R4 result via immediate" : tag_of(op), result, m[31:0]);
        @(posedge clk);
        #1;
        if (cc) mflags = m[35:32];
        if (!cc) check("R9 psr held", psr, psr_of(mflags));
        else begin
            check("R5 N/Z", {30'h0, psr[23], psr[22]}, {30'h0, mflags[3], mflags[2]});
            if (op <= 3'd1) begin
                check("R6 carry", {31'h0, psr[20]}, {31'h0, mflags[0]});
                check("R7 overflow", {31'h0, psr[21]}, {31'h0, mflags[1]});
            end else begin
                check("R8 C/V cleared", {30'h0, psr[21], psr[20]}, 32'h0);
            end
            check("R10 psr layout", psr, psr_of(mflags));
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] corner [0:4];
        corner[0] = 32'h0; corner[1] = 32'hFFFF_FFFF; corner[2] = 32'h7FFF_FFFF;
        corner[3] = 32'h8000_0000; corner[4] = 32'h1;
        void'($urandom(32'd20071));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset psr zero", psr, 32'h0);
        rst = 1'b0;

        // directed corners
        run_op(3'd0, 1, 0, 32'h7FFF_FFFF, 32'h1, 13'h0);      // R7 overflow, N=1
        run_op(3'd0, 1, 0, 32'hFFFF_FFFF, 32'h1, 13'h0);      // R6 carry, Z=1
        run_op(3'd1, 1, 0, 32'h0, 32'h1, 13'h0);              // R6 borrow
        run_op(3'd1, 1, 0, 32'h5, 32'h5, 13'h0);              // Z, no borrow
        run_op(3'd1, 1, 0, 32'h8000_0000, 32'h1, 13'h0);      // R7 sub overflow
        run_op(3'd0, 1, 1, 32'h1, 32'hDEAD_BEEF, 13'h1FFF);   // R4 imm -1
        run_op(3'd0, 1, 1, 32'h0, 32'h0, 13'h1000);           // R4 most negative imm
        run_op(3'd0, 1, 0, 32'hFFFF_FFFF, 32'h1, 13'h0);      // set C
        run_op(3'd2, 1, 0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 13'h0); // R8 clears C
        run_op(3'd0, 1, 0, 32'h8000_0000, 32'h8000_0000, 13'h0); // C and V set
        run_op(3'd1, 0, 0, 32'h3, 32'h3, 13'h0);              // R9 plain keeps
        run_op(3'd4, 1, 0, 32'h0, 32'h1234_5678, 13'h0);      // R3 not ignores b
        run_op(3'd3, 0, 0, 32'h0, 32'h0, 13'h0);              // R9
        run_op(3'd6, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 13'h0); // R11

        // random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = ($urandom % 4 == 0) ? corner[$urandom % 5] : $urandom;
            b = ($urandom % 4 == 0) ? corner[$urandom % 5] : $urandom;
            run_op(3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 3 == 0), a, b, 13'($urandom));
        end

        // synchronous reset mid-run
        run_op(3'd1, 1, 0, 32'h0, 32'h1, 13'h0);
        @(negedge clk);
        rst = 1'b1; set_cc = 1'b1;
        @(posedge clk);
        #1;
        check("R10 sync reset clears psr", psr, 32'h0);
        rst = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule